// File: doc/BRIEF.md
# Fractional Nanosecond Sample-Tick Generator

This block creates the 16x oversampling tick that paces a UART's receive and transmit shifters. The divisor is not a count of clock cycles. Software writes the wanted sample period as a time in nanoseconds, with a fraction in steps of 1/255 ns. Each reference clock stands for 16 ns of elapsed time. The block keeps a running phase in units of 1/255 ns, so the average spacing between ticks equals the programmed period, even when that period is not a whole number of clocks.

A second output, the bit strobe, marks every sixteenth sample tick. A write to the divisor restarts both the phase and the sixteen-tick count. An integer field of zero stops the generator. If the programmed period is at most one clock, the block ticks on every clock and never more often. This caps the rate at one tick per clock.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the divisor is zero, and `sample_tick` and `bit_strobe` stay low until a divisor is written.
- R2: A write to byte offset 0x54 loads the divisor. Bits 31:8 are the integer nanoseconds and bits 7:0 the fraction in 1/255 ns. The period in units is P = integer*255 + fraction.
- R3: Let a divisor write be accepted at clock edge 0, with P greater than 4080 units (one clock). The k-th sample tick is then high for exactly the cycle that follows edge ceil(k*P/4080).
- R4: When P is from 255 up to 4080 units, `sample_tick` is high in every cycle after the write edge, one tick per clock at most.
- R5: `bit_strobe` is high together with the 16th, 32nd, 48th ... sample tick counted from the last divisor write, and never without a tick.
- R6: Rewriting the divisor, even with the same value, clears the phase and the tick count. Ticks and strobes then follow R3 from the new write edge, and both outputs are low in the cycle after that edge.
- R7: While the integer field is zero, both outputs stay low whatever the fraction field holds.
- R8: With integer 41 and fraction 170, the 10000th tick after a write follows edge ceil(10000*P/4080) = 26042.
- R9: Writes to any byte offset other than 0x54 leave the divisor and the tick phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; each edge stands for 16 ns of time |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Full-word write data |
| sample_tick | output | 1 | One-cycle 16x oversampling tick |
| bit_strobe | output | 1 | High on every sixteenth sample tick |

## Verification
The bench builds the block with its default parameters: a 24-bit integer field, an 8-bit fraction with a denominator of 255, 16 ns per clock, sixteen ticks per bit and the divisor at offset 0x54. These values bring the 1.5 Mbit/s setting within reach, where the period of 10625 units is not a multiple of the 4080-unit step, so the remainder carry is exercised on every tick. They also cover periods at and below one clock, which reach the one-tick-per-clock cap, and an exact two-clock period. A slow 115200 bit/s setting runs long enough for several bit strobes to occur.

// File: rtl/baud_gen_pkg.sv
// Shared constants and the operating-mode type of the fractional baud generator.
// Assumes: time is counted in units of 1/FRAC_DEN ns.
package baud_gen_pkg;

    localparam int unsigned BG_INT_W      = 24;    // integer-nanosecond field width
    localparam int unsigned BG_FRAC_W     = 8;     // fraction field width
    localparam int unsigned BG_FRAC_DEN   = 255;   // fraction denominator
    localparam int unsigned BG_CLK_NS     = 16;    // nanoseconds per reference clock
    localparam int unsigned BG_OVERSAMPLE = 16;    // sample ticks per serial bit
    localparam int unsigned BG_ADDR_W     = 8;     // byte address width of the window
    localparam int unsigned BG_DIV_OFS    = 'h54;  // divisor register byte offset

    // Mode picked from the programmed period
    typedef enum logic [1:0] {
        BG_IDLE   = 2'd0,   // integer field zero: no ticks
        BG_FAST   = 2'd1,   // period at most one clock: tick every clock
        BG_NORMAL = 2'd2    // period longer than one clock: carry remainder
    } bg_mode_e;

endpackage

// File: rtl/baud_div_reg.sv
// Divisor register of the baud generator.
// Decodes a full-word write at DIV_OFS and holds the 32-bit divisor.
// Assumes: writes are always whole words; there is no read path.
module baud_div_reg #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DIV_W  = 32,
    parameter int unsigned DIV_OFS = 'h54
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DIV_W-1:0]  wr_data,
    output logic              load,
    output logic [DIV_W-1:0]  div_q
);

    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(DIV_OFS);

    // Address match for the divisor word
    assign load = wr_en && (wr_addr == OFS);

    // Capture the divisor on a matching write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (load) begin
            div_q <= wr_data;
        end
    end

endmodule

// File: rtl/baud_phase_acc.sv
// Phase accumulator of the baud generator.
// Adds STEP units of time per clock and emits a tick when the sum
// reaches the period, keeping the remainder (NORMAL mode). FAST mode
// ticks every clock with the phase held at zero. IDLE and load clear it.
// Assumes: the period only changes together with load.
module baud_phase_acc
    import baud_gen_pkg::*;
#(
    parameter int unsigned ACC_W = 33,
    parameter int unsigned STEP  = 4080
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  bg_mode_e         mode,
    input  logic [ACC_W-1:0] period,
    output logic             tick_next,
    output logic             tick_q,
    output logic [ACC_W-1:0] acc_q
);

    localparam int unsigned SUM_W = ACC_W + 1;

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] rem;

    // Elapsed time after this clock, and what is left after one period
    assign sum = {1'b0, acc_q} + SUM_W'(STEP);
    assign rem = sum - {1'b0, period};

    // A tick is due when the elapsed time covers the period
    assign tick_next = !load && (mode != BG_IDLE) && (sum >= {1'b0, period});

    // Register the tick and advance or clear the phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= tick_next;
            if (load || mode != BG_NORMAL) begin
                acc_q <= '0;
            end else if (tick_next) begin
                acc_q <= rem[ACC_W-1:0];
            end else begin
                acc_q <= sum[ACC_W-1:0];
            end
        end
    end

endmodule

// File: rtl/baud_bit_count.sv
// Bit strobe of the baud generator.
// Counts sample ticks and raises the strobe with every OVERSAMPLE-th one.
// Assumes: tick_next is the combinational tick registered in step with it.
module baud_bit_count #(
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick_next,
    output logic strobe_q
);

    generate
        if (OVERSAMPLE <= 1) begin : g_direct
            // Every tick is a bit boundary
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    strobe_q <= 1'b0;
                end else begin
                    strobe_q <= tick_next;
                end
            end
        end else begin : g_count
            localparam int unsigned CNT_W = $clog2(OVERSAMPLE);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

            logic [CNT_W-1:0] cnt_q;

            // Count ticks, wrap at LAST and strobe on the wrap
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    cnt_q    <= '0;
                    strobe_q <= 1'b0;
                end else if (tick_next) begin
                    strobe_q <= (cnt_q == LAST);
                    cnt_q    <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                end else begin
                    strobe_q <= 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/frac_baud_gen.sv
// Fractional nanosecond sample-tick generator (top).
// Turns a divisor in ns + 1/FRAC_DEN ns into a sample tick whose average
// spacing equals that period, plus a strobe every OVERSAMPLE ticks.
// Assumes: each clock represents CLK_NS nanoseconds.
module frac_baud_gen
    import baud_gen_pkg::*;
#(
    parameter int unsigned INT_W      = BG_INT_W,
    parameter int unsigned FRAC_W     = BG_FRAC_W,
    parameter int unsigned FRAC_DEN   = BG_FRAC_DEN,
    parameter int unsigned CLK_NS     = BG_CLK_NS,
    parameter int unsigned OVERSAMPLE = BG_OVERSAMPLE,
    parameter int unsigned ADDR_W     = BG_ADDR_W,
    parameter int unsigned DIV_OFS    = BG_DIV_OFS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [INT_W+FRAC_W-1:0]   wr_data,
    output logic                      sample_tick,
    output logic                      bit_strobe
);

    localparam int unsigned DIV_W = INT_W + FRAC_W;
    localparam int unsigned ACC_W = DIV_W + 1;
    localparam int unsigned STEP  = CLK_NS * FRAC_DEN;

    logic             load;
    logic [DIV_W-1:0] div_q;
    logic [INT_W-1:0] div_int;
    logic [FRAC_W-1:0] div_frac;
    logic [ACC_W-1:0] period_u;
    logic [ACC_W-1:0] acc_q;
    logic             tick_next;
    bg_mode_e         mode;

    baud_div_reg #(
        .ADDR_W (ADDR_W),
        .DIV_W  (DIV_W),
        .DIV_OFS(DIV_OFS)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .load   (load),
        .div_q  (div_q)
    );

    // Split the divisor into its fields
    assign div_int  = div_q[DIV_W-1:FRAC_W];
    assign div_frac = div_q[FRAC_W-1:0];

    // Period in 1/FRAC_DEN ns units
    assign period_u = ACC_W'(div_int) * ACC_W'(FRAC_DEN) + ACC_W'(div_frac);

    // Pick the operating mode from the period
    always_comb begin
        if (div_int == '0) begin
            mode = BG_IDLE;
        end else if (period_u <= ACC_W'(STEP)) begin
            mode = BG_FAST;
        end else begin
            mode = BG_NORMAL;
        end
    end

    baud_phase_acc #(
        .ACC_W(ACC_W),
        .STEP (STEP)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .mode     (mode),
        .period   (period_u),
        .tick_next(tick_next),
        .tick_q   (sample_tick),
        .acc_q    (acc_q)
    );

    baud_bit_count #(
        .OVERSAMPLE(OVERSAMPLE)
    ) u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (load || mode == BG_IDLE),
        .tick_next(tick_next),
        .strobe_q (bit_strobe)
    );

endmodule

// File: rtl/frac_baud_gen_chk.sv
// Assertion checker for frac_baud_gen, attached by bind below.
// Assumes: it sees the top's ports plus the divisor, period and phase.
module frac_baud_gen_chk #(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned INT_W   = 24,
    parameter int unsigned ACC_W   = 33,
    parameter int unsigned STEP    = 4080,
    parameter int unsigned DIV_OFS = 'h54
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [INT_W-1:0]  div_int,
    input logic [ACC_W-1:0]  period_u,
    input logic [ACC_W-1:0]  acc_q,
    input logic              sample_tick,
    input logic              bit_strobe
);

    logic hit;
    logic running;
    assign hit     = wr_en && (wr_addr == ADDR_W'(DIV_OFS));
    assign running = (div_int != '0);

    // R5: a strobe never stands without its tick
    p_strobe_with_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> sample_tick);

    // R7: an integer field of zero keeps both outputs low
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!sample_tick && !bit_strobe));

    // R6: the cycle after a divisor write starts clean
    p_write_restarts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (!sample_tick && !bit_strobe));

    // R4: a period of at most one clock ticks on the following clock
    p_fast_every_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && running && period_u <= ACC_W'(STEP)) |=> sample_tick);

    // R3: the carried remainder stays below one period
    p_phase_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && period_u > ACC_W'(STEP)) |-> (acc_q < period_u));

endmodule

bind frac_baud_gen frac_baud_gen_chk #(
    .ADDR_W (ADDR_W),
    .INT_W  (INT_W),
    .ACC_W  (ACC_W),
    .STEP   (STEP),
    .DIV_OFS(DIV_OFS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .div_int    (div_int),
    .period_u   (period_u),
    .acc_q      (acc_q),
    .sample_tick(sample_tick),
    .bit_strobe (bit_strobe)
);

// File: tb/frac_baud_gen_bench.sv
// Directed bench for frac_baud_gen: one task per scenario.
// Expected ticks come from the closed form in the requirements:
// ticks up to edge n = floor(n*4080/P), or n when P <= 4080.
module frac_baud_gen_bench;

    localparam longint S = 4080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = 8'h00;
    logic [31:0] wr_data = 32'h0;
    logic        sample_tick;
    logic        bit_strobe;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    frac_baud_gen u_frac_baud_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .sample_tick(sample_tick),
        .bit_strobe (bit_strobe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint ticks_upto(input longint p, input longint n);
        if (p == 0) return 0;
        if (p <= S) return n;
        return (n * S) / p;
    endfunction

    function automatic longint period_of(input longint i, input longint f);
        if (i == 0) return 0;
        return i * 255 + f;
    endfunction

    // Write a word; returns at the negedge after the accepting edge (edge 0)
    task automatic write_word(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Compare edges n0+1 .. n0+ncyc against the closed-form schedule
    task automatic check_range(input longint p, input longint n0, input int ncyc,
                               input string rt, input string rs);
        int tick_bad = 0;
        int str_bad  = 0;
        for (int i = 1; i <= ncyc; i++) begin
            longint n = n0 + i;
            bit et, es;
            @(posedge clk);
            @(negedge clk);
            wr_en = 1'b0;
            et = ticks_upto(p, n) != ticks_upto(p, n - 1);
            es = et && (ticks_upto(p, n) % 16 == 0);
            if (sample_tick !== et) tick_bad++;
            if (bit_strobe !== es) str_bad++;
        end
        check(tick_bad == 0, rt, "tick mismatch cycles", tick_bad, 0);
        check(str_bad == 0, rs, "strobe mismatch cycles", str_bad, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(sample_tick == 1'b0, "R1", "tick in reset", sample_tick, 0);
        check(bit_strobe == 1'b0, "R1", "strobe in reset", bit_strobe, 0);
        rst_n = 1'b1;
        check_range(0, 0, 50, "R1", "R1");
    endtask

    task automatic t_fine_rate();
        // 1.5 Mbit/s: integer 41 ns, fraction 170
        write_word(8'h54, {24'd41, 8'd170});
        check_range(period_of(41, 170), 0, 600, "R3", "R5");
    endtask

    task automatic t_slow_rate();
        // 115200 bit/s: integer 542 ns, fraction 136
        write_word(8'h54, {24'd542, 8'd136});
        check_range(period_of(542, 136), 0, 2000, "R3", "R5");
    endtask

    task automatic t_fields();
        // exact two-clock period, then a full fraction
        write_word(8'h54, {24'd32, 8'd0});
        check_range(period_of(32, 0), 0, 200, "R2", "R2");
        write_word(8'h54, {24'd20, 8'd254});
        check_range(period_of(20, 254), 0, 300, "R2", "R5");
    endtask

    task automatic t_fast();
        write_word(8'h54, {24'd1, 8'd0});
        check_range(period_of(1, 0), 0, 100, "R4", "R5");
        write_word(8'h54, {24'd16, 8'd0});
        check_range(period_of(16, 0), 0, 100, "R4", "R5");
    endtask

    task automatic t_restart();
        write_word(8'h54, {24'd41, 8'd170});
        repeat (37) @(posedge clk);
        write_word(8'h54, {24'd41, 8'd170});
        check_range(period_of(41, 170), 0, 300, "R6", "R6");
    endtask

    task automatic t_other_offset();
        write_word(8'h54, {24'd41, 8'd170});
        check_range(period_of(41, 170), 0, 100, "R9", "R9");
        wr_en = 1'b1; wr_addr = 8'h50; wr_data = {24'd1, 8'd0};
        check_range(period_of(41, 170), 100, 150, "R9", "R9");
        wr_en = 1'b1; wr_addr = 8'h58; wr_data = {24'd0, 8'd0};
        check_range(period_of(41, 170), 250, 150, "R9", "R9");
    endtask

    task automatic t_idle();
        write_word(8'h54, {24'd0, 8'd200});
        check_range(0, 0, 300, "R7", "R7");
    endtask

    task automatic t_long_run();
        longint p = period_of(41, 170);
        longint exp_n = (10000 * p + S - 1) / S;
        longint n = 0;
        int ticks = 0;
        write_word(8'h54, {24'd41, 8'd170});
        while (ticks < 10000 && n < 40000) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (sample_tick) ticks++;
        end
        check(n == exp_n, "R8", "edge of tick 10000", n, exp_n);
    endtask

    initial begin
        t_reset();
        t_fine_rate();
        t_slow_rate();
        t_fields();
        t_fast();
        t_restart();
        t_other_offset();
        t_idle();
        t_long_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule